// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block supplies the two ALU operands of the instruction in the execute stage of a five-stage in-order integer pipeline. It holds the integer register file, whose write port is driven by the writeback stage (the MEM/WB pipeline register). It also compares the source register numbers of the executing instruction against the destinations of the two younger-result pipeline registers, EX/MEM and MEM/WB. When a source matches a pending result, the operand is taken from that pipeline register rather than from the stale register file value.

Each cycle the decode stage presents its two source register numbers. The register file is read with write-before-read semantics: a register written back in the same cycle returns the new value. The read values and source numbers are captured into an internal execute-stage latch at the next clock edge. In the following cycle the forwarding compare picks a source for each operand. Only dependencies one and two instructions apart use the forwarding paths. A dependency three apart is resolved inside the register file.

Top module: `opfwd_top`

## Requirements
- R1: When EX/MEM write-enable is high, its destination is nonzero and equals the execute-stage first source, `fwd_sel_a_o` is 2'b10 and `op_a_o` equals `exmem_data_i`.
- R2: The same rule applied to the second source drives `fwd_sel_b_o` = 2'b10 and `op_b_o` = `exmem_data_i`.
- R3: When the EX/MEM rule does not hold for an operand but the MEM/WB destination matches the source under the same conditions, the select is 2'b01 and the operand equals `memwb_data_i`.
- R4: When both EX/MEM and MEM/WB match the same source, the EX/MEM value wins and the select is 2'b10.
- R5: A stage whose write-enable is low, or whose destination is register 0, never causes forwarding. When no stage forwards, the select is 2'b00 and the operand is the register file value captured at the previous edge.
- R6: A register file read in the same cycle as a writeback to that register returns the written data. A consumer three instructions behind its producer therefore gets the new value with select 2'b00.
- R7: Register 0 always reads as zero, and writebacks to it are discarded.
- R8: After reset all registers and the execute-stage source latch are zero, so both selects are 2'b00 and both operands are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | 5 | Decode-stage first source register |
| id_rs2_i | input | 5 | Decode-stage second source register |
| exmem_we_i | input | 1 | EX/MEM register write-enable |
| exmem_rd_i | input | 5 | EX/MEM destination register |
| exmem_data_i | input | 32 | EX/MEM result |
| memwb_we_i | input | 1 | MEM/WB write-enable, also the register file write strobe |
| memwb_rd_i | input | 5 | MEM/WB destination register |
| memwb_data_i | input | 32 | MEM/WB result, also the register file write data |
| fwd_sel_a_o | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b_o | output | 2 | Operand B source, same encoding |
| op_a_o | output | 32 | Execute-stage operand A |
| op_b_o | output | 32 | Execute-stage operand B |

## Verification
The assertions assume that the EX/MEM and MEM/WB inputs are valid throughout every cycle once reset is released. They also assume that the decode sources presented in one cycle belong to the instruction that is executing in the next cycle, with no stalls. The stimulus drives every input once per cycle, away from the clock edge. It draws register numbers from a small range so that matches, double matches and register-0 destinations occur often. Directed sequences add a chain of dependent instructions at distances one, two and three, a double match, and a writeback to register 0.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_EM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/opfwd_regfile.sv
module opfwd_regfile #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        wa_i,
  input  logic [XLEN-1:0]      wd_i,
  input  logic [NRD-1:0][AW-1:0]   ra_i,
  output logic [NRD-1:0][XLEN-1:0] rd_o
);
  logic [XLEN-1:0] regs_q [1:NREG-1];
  logic            wr_en;

  assign wr_en = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    // write-before-read: same-cycle writeback is visible to the reader
    always_comb begin
      if (ra_i[p] == '0)                  rd_o[p] = '0;
      else if (wr_en && wa_i == ra_i[p])  rd_o[p] = wd_i;
      else                                rd_o[p] = regs_q[ra_i[p]];
    end

    AST_X0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ra_i[p] == '0) |-> (rd_o[p] == '0)); // R7
    AST_WRITE_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wa_i != '0 && wa_i == ra_i[p]) |-> (rd_o[p] == wd_i)); // R6
  end
endmodule

// File: rtl/opfwd_sel.sv
module opfwd_sel
  import opfwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rs_i,
  input  logic          em_we_i,
  input  logic [AW-1:0] em_rd_i,
  input  logic          mw_we_i,
  input  logic [AW-1:0] mw_rd_i,
  output fwd_sel_e      sel_o
);
  logic em_hit, mw_hit;

  assign em_hit = em_we_i && (em_rd_i != '0) && (em_rd_i == rs_i);
  assign mw_hit = mw_we_i && (mw_rd_i != '0) && (mw_rd_i == rs_i);

  always_comb begin
    if (em_hit)      sel_o = SEL_EM;  // most recent result wins
    else if (mw_hit) sel_o = SEL_MW;
    else             sel_o = SEL_RF;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11); // R5
  AST_X0_NEVER_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i == '0) |-> (sel_o == SEL_RF)); // R5
  AST_EM_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (em_we_i && mw_we_i && em_rd_i == mw_rd_i && em_rd_i == rs_i && rs_i != '0)
      |-> (sel_o == SEL_EM)); // R4
endmodule

// File: rtl/opfwd_top.sv
module opfwd_top
  import opfwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int NOP = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   id_rs1_i,
  input  logic [AW-1:0]   id_rs2_i,
  input  logic            exmem_we_i,
  input  logic [AW-1:0]   exmem_rd_i,
  input  logic [XLEN-1:0] exmem_data_i,
  input  logic            memwb_we_i,
  input  logic [AW-1:0]   memwb_rd_i,
  input  logic [XLEN-1:0] memwb_data_i,
  output logic [1:0]      fwd_sel_a_o,
  output logic [1:0]      fwd_sel_b_o,
  output logic [XLEN-1:0] op_a_o,
  output logic [XLEN-1:0] op_b_o
);
  logic [NOP-1:0][AW-1:0]   id_rs;
  logic [NOP-1:0][XLEN-1:0] rf_rd;
  logic [NOP-1:0][AW-1:0]   ex_rs_q;
  logic [NOP-1:0][XLEN-1:0] ex_rf_q;
  fwd_sel_e                 sel [NOP];
  logic [NOP-1:0][XLEN-1:0] op;

  assign id_rs[0] = id_rs1_i;
  assign id_rs[1] = id_rs2_i;

  opfwd_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NOP)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (memwb_we_i),
    .wa_i  (memwb_rd_i),
    .wd_i  (memwb_data_i),
    .ra_i  (id_rs),
    .rd_o  (rf_rd)
  );

  for (genvar k = 0; k < NOP; k++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ex_rs_q[k] <= '0;
        ex_rf_q[k] <= '0;
      end else begin
        ex_rs_q[k] <= id_rs[k];
        ex_rf_q[k] <= rf_rd[k];
      end
    end

    opfwd_sel #(.AW(AW)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rs_i   (ex_rs_q[k]),
      .em_we_i(exmem_we_i),
      .em_rd_i(exmem_rd_i),
      .mw_we_i(memwb_we_i),
      .mw_rd_i(memwb_rd_i),
      .sel_o  (sel[k])
    );

    always_comb begin
      unique case (sel[k])
        SEL_EM:  op[k] = exmem_data_i;
        SEL_MW:  op[k] = memwb_data_i;
        default: op[k] = ex_rf_q[k];
      endcase
    end
  end

  assign fwd_sel_a_o = sel[0];
  assign fwd_sel_b_o = sel[1];
  assign op_a_o      = op[0];
  assign op_b_o      = op[1];

  AST_FWD_A_EM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_a_o == 2'b10) |-> (op_a_o == exmem_data_i)); // R1
  AST_FWD_B_EM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_b_o == 2'b10) |-> (op_b_o == exmem_data_i)); // R2
  AST_FWD_A_MW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_a_o == 2'b01) |-> (op_a_o == memwb_data_i)); // R3
  AST_FWD_B_MW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_b_o == 2'b01) |-> (op_b_o == memwb_data_i)); // R3
endmodule

// File: tb/opfwd_top_tb_top.sv
module opfwd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  id_rs1 = '0, id_rs2 = '0;
  logic        em_we = 1'b0, mw_we = 1'b0;
  logic [4:0]  em_rd = '0, mw_rd = '0;
  logic [31:0] em_d = '0, mw_d = '0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_regs [32];
  logic [4:0]  m_rs [2];
  logic [31:0] m_rf [2];

  always #4 clk = ~clk;

  opfwd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .exmem_we_i(em_we), .exmem_rd_i(em_rd), .exmem_data_i(em_d),
    .memwb_we_i(mw_we), .memwb_rd_i(mw_rd), .memwb_data_i(mw_d),
    .fwd_sel_a_o(sel_a), .fwd_sel_b_o(sel_b), .op_a_o(op_a), .op_b_o(op_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] rs);
    if (em_we && em_rd != 0 && em_rd == rs) return 2'b10;
    if (mw_we && mw_rd != 0 && mw_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag(input int k, input logic [4:0] rs, input logic [1:0] s);
    if (s == 2'b10) begin
      if (mw_we && mw_rd == rs) return "R4";
      return (k == 0) ? "R1" : "R2";
    end
    if (s == 2'b01) return "R3";
    if (rs == 0) return "R7";
    if ((em_we && em_rd == rs) || (mw_we && mw_rd == rs)) return "R5";
    return "R6";
  endfunction

  function automatic logic [31:0] rf_read(input logic [4:0] ra);
    if (ra == 0) return '0;
    if (mw_we && mw_rd == ra) return mw_d;
    return m_regs[ra];
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] r1, input logic [4:0] r2,
                      input logic ewe, input logic [4:0] erd, input logic [31:0] ed,
                      input logic wwe, input logic [4:0] wrd, input logic [31:0] wd);
    @(negedge clk);
    id_rs1 = r1; id_rs2 = r2;
    em_we = ewe; em_rd = erd; em_d = ed;
    mw_we = wwe; mw_rd = wrd; mw_d = wd;
    #1;
    for (int k = 0; k < 2; k++) begin
      logic [1:0]  es;
      logic [31:0] eo;
      string       t;
      es = exp_sel(m_rs[k]);
      eo = (es == 2'b10) ? em_d : (es == 2'b01) ? mw_d : m_rf[k];
      t  = tag(k, m_rs[k], es);
      chk({t, " sel"}, {30'd0, (k == 0) ? sel_a : sel_b}, {30'd0, es});
      chk({t, " op"}, (k == 0) ? op_a : op_b, eo);
    end
    m_rf[0] = rf_read(r1);
    m_rf[1] = rf_read(r2);
    m_rs[0] = r1;
    m_rs[1] = r2;
    if (wwe && wrd != 0) m_regs[wrd] = wd;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_rs[0] = '0; m_rs[1] = '0; m_rf[0] = '0; m_rf[1] = '0;
    void'($urandom(32'd1234));
    #20;
    // R8: reset state
    chk("R8 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R8 sel_b", {30'd0, sel_b}, 32'd0);
    chk("R8 op_a", op_a, 32'd0);
    chk("R8 op_b", op_b, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // dependent chain: sub x2; and x12,x2,x5; or x13,x6,x2; add x14,x2,x2
    step(5'd1, 5'd3, 0, 0, 0, 0, 0, 0);
    step(5'd2, 5'd5, 0, 0, 0, 0, 0, 0);
    step(5'd6, 5'd2, 1, 5'd2, 32'h0000_1234, 0, 0, 0);               // R1 on and
    step(5'd2, 5'd2, 1, 5'd12, 32'h0000_00aa, 1, 5'd2, 32'h0000_1234); // R3 on or
    step(5'd0, 5'd0, 1, 5'd13, 32'h0000_00bb, 1, 5'd12, 32'h0000_00aa); // R6 on add
    step(5'd0, 5'd0, 0, 0, 0, 1, 5'd13, 32'h0000_00bb);
    // R4: both stages write x3, consumer reads x3 on both sides
    step(5'd3, 5'd3, 0, 0, 0, 0, 0, 0);
    step(5'd0, 5'd0, 1, 5'd3, 32'h1111_1111, 1, 5'd3, 32'h2222_2222);
    // R7/R5: writeback to x0, then read x0, with rd=0 in EX/MEM
    step(5'd0, 5'd0, 0, 0, 0, 1, 5'd0, 32'hdead_beef);
    step(5'd0, 5'd0, 1, 5'd0, 32'hcafe_f00d, 1, 5'd0, 32'h1234_5678);
    // R5: matching destinations with write-enable low
    step(5'd4, 5'd4, 0, 0, 0, 0, 0, 0);
    step(5'd0, 5'd0, 0, 5'd4, 32'h5555_0000, 0, 5'd4, 32'h6666_0000);

    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 7), $urandom_range(0, 7),
           1'($urandom_range(0, 1)), 5'($urandom_range(0, 7)), $urandom(),
           1'($urandom_range(0, 1)), 5'($urandom_range(0, 7)), $urandom());
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule